// File: doc/BRIEF.md
# Rail Limit Guard

The rail limit guard watches a stream of channel-tagged conversion results from eleven supply and sensor channels. Each channel owns four programmable 16-bit limit words: two under-limits and two over-limits. A limit word holds a 10-bit threshold and four trigger-class bits. A sample that lies past a threshold drives every output class flagged in that limit word: reset, healthy, power-off and shutdown. Only excursions on limits that carry the reset, power-off or shutdown class count as critical. A critical excursion sets the channel's bit in a sticky fault word.

Samples arrive on a valid/ready stream. The guard evaluates one sample per cycle, so `smp_ready` is high whenever the block is out of reset. A sample is taken on any cycle where `smp_valid` and `smp_ready` are both high. A producer may hold `smp_valid` high for back-to-back samples. Limit words are written and read one byte at a time through a plain register port. Reads are combinational.

Top module: `rail_limit_guard`

## Requirements
- R1: After reset the fault word is 0, `reset_req`, `poweroff_req` and `shutdown_req` are low, `healthy` is high, every limit byte reads 0, and `smp_ready` is high.
- R2: Limit k (0..3) of channel c (0..10) is stored at byte address 0x80 + 8c + 2k, high byte first, so its low byte sits at the next address. A write takes effect at the clock edge, and `reg_rdata` shows the addressed byte in the same cycle. Addresses outside 0x80..0xD7 read 0, and writes to them change nothing.
- R3: In a limit word, bit 15 selects the reset class, bit 14 healthy, bit 13 power-off, bit 12 shutdown, and bits 9:0 hold the threshold. Bits 11:10 are stored and read back but have no effect on any output.
- R4: Limits 0 and 1 are under-limits: a sample strictly below the threshold is an excursion. Limits 2 and 3 are over-limits: a sample strictly above the threshold is an excursion. A sample equal to the threshold is never an excursion.
- R5: On channel 8 (temperature), samples and thresholds compare as 10-bit two's-complement values, so codes above 511 are negative. All other channels compare as unsigned values.
- R6: A taken sample with an excursion on a limit carrying bit 15, 13 or 12 sets bit c of `fault_word` in the next cycle. Bit index equals channel index: 0-5 rails A-F, 6 VDD, 7 12V input, 8 temperature, 9 and 10 the auxiliary inputs. An excursion on a healthy-only limit sets no fault bit.
- R7: Fault bits stay set until a cycle with `clr_strobe` high whose `clr_mask` has that bit set. A bit being set in that same cycle stays set.
- R8: `reset_req`, `poweroff_req` and `shutdown_req` are registered. Each is high for exactly the cycle after a taken sample that has an excursion on a limit carrying that class bit. Otherwise it is low.
- R9: Each channel holds a healthy-excursion flag, which every taken sample of that channel rewrites. `healthy` is high, from the cycle after the sample, exactly when no channel's flag is set.
- R10: A sample tagged with a channel above 10 is dropped. It changes no output and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample present |
| smp_ready | output | 1 | Guard accepts a sample this cycle |
| smp_chan | input | 4 | Channel tag of the sample |
| smp_code | input | 10 | Conversion code |
| reg_wr | input | 1 | Byte write strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte for `reg_addr` |
| clr_strobe | input | 1 | Apply fault clear mask |
| clr_mask | input | 11 | Fault bits to clear |
| fault_word | output | 11 | Sticky critical-fault bits, one per channel |
| reset_req | output | 1 | Reset-class excursion pulse |
| healthy | output | 1 | No healthy-class excursion active |
| poweroff_req | output | 1 | Power-off-class excursion pulse |
| shutdown_req | output | 1 | Shutdown-class excursion pulse |

## Verification
The bench drives samples equal to the threshold and one code on either side of it. A design that used the wrong comparison, such as >= or <=, would flag the equal-code samples. On the temperature channel it places negative codes that an unsigned compare would misjudge, in both directions. It also checks that a healthy-only excursion pulls `healthy` low and leaves the fault word alone. A design that counted bit 14 as critical would set a fault bit there. It clears a fault bit in the same cycle a new fault sets it, and a design that let the clear win would lose that fault. It also sends out-of-range channel tags and register addresses, which a design with loose decoding would alias onto real channels.

// File: rtl/rlg_pkg.sv
package rlg_pkg;
  localparam int CODE_W     = 10;
  localparam int LIM_PER_CH = 4;
  localparam int UNDER_CNT  = 2;
  localparam int CLS_W      = 4;

  typedef struct packed {
    logic              trig_rst;
    logic              trig_hlth;
    logic              trig_poff;
    logic              trig_shdn;
    logic [1:0]        spare;
    logic [CODE_W-1:0] thr;
  } limit_word_t;

  typedef struct packed {
    logic rst;
    logic hlth;
    logic poff;
    logic shdn;
  } class_hits_t;
endpackage

// File: rtl/rlg_limit_regs.sv
module rlg_limit_regs
  import rlg_pkg::*;
#(
  parameter int                NUM_CH    = 11,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h80,
  localparam int               CH_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [CH_W-1:0]   lk_ch,
  output logic [CODE_W-1:0] lk_thr [LIM_PER_CH],
  output logic [CLS_W-1:0]  lk_cls [LIM_PER_CH]
);
  localparam int OFF_W = CH_W + 3;
  localparam int SPAN  = NUM_CH * 8;

  limit_word_t      mem [NUM_CH][LIM_PER_CH];
  logic             hit;
  logic [OFF_W-1:0] off;
  logic [CH_W-1:0]  sel_ch;
  logic [1:0]       sel_k;
  logic             sel_lo;

  assign hit    = (int'(addr) >= int'(BASE_ADDR)) && (int'(addr) < int'(BASE_ADDR) + SPAN);
  assign off    = OFF_W'(addr - BASE_ADDR);
  assign sel_ch = off[OFF_W-1:3];
  assign sel_k  = off[2:1];
  assign sel_lo = off[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++)
        for (int k = 0; k < LIM_PER_CH; k++)
          mem[c][k] <= '0;
    end else if (wr_en && hit) begin
      if (sel_lo) mem[sel_ch][sel_k][7:0]  <= wdata;
      else        mem[sel_ch][sel_k][15:8] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) rdata = sel_lo ? mem[sel_ch][sel_k][7:0] : mem[sel_ch][sel_k][15:8];
  end

  for (genvar k = 0; k < LIM_PER_CH; k++) begin : g_lookup
    assign lk_thr[k] = mem[lk_ch][k].thr;
    assign lk_cls[k] = {mem[lk_ch][k].trig_rst, mem[lk_ch][k].trig_hlth,
                        mem[lk_ch][k].trig_poff, mem[lk_ch][k].trig_shdn};
  end

  // R2: a write to an address outside the window never shows in read data there
  a_r2_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> rdata == 8'h00);
endmodule

// File: rtl/rlg_excursion_eval.sv
module rlg_excursion_eval
  import rlg_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              is_signed,
  input  logic [CODE_W-1:0] thr [LIM_PER_CH],
  input  logic [CLS_W-1:0]  cls [LIM_PER_CH],
  output class_hits_t       hits
);
  logic [LIM_PER_CH-1:0] ex, rv, hv, pv, sv;

  for (genvar k = 0; k < LIM_PER_CH; k++) begin : g_lim
    logic below, above;
    always_comb begin
      if (is_signed) begin
        below = $signed(code) < $signed(thr[k]);
        above = $signed(code) > $signed(thr[k]);
      end else begin
        below = code < thr[k];
        above = code > thr[k];
      end
    end
    if (k < UNDER_CNT) begin : g_under
      assign ex[k] = below;
    end else begin : g_over
      assign ex[k] = above;
    end
    assign rv[k] = ex[k] & cls[k][3];
    assign hv[k] = ex[k] & cls[k][2];
    assign pv[k] = ex[k] & cls[k][1];
    assign sv[k] = ex[k] & cls[k][0];
  end

  assign hits = '{rst: |rv, hlth: |hv, poff: |pv, shdn: |sv};
endmodule

// File: rtl/rlg_fault_tracker.sv
module rlg_fault_tracker
  import rlg_pkg::*;
#(
  parameter int  NUM_CH = 11,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [CH_W-1:0]   ch,
  input  class_hits_t       hits,
  input  logic              clr_strobe,
  input  logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] fault_o,
  output logic              rst_o,
  output logic              poff_o,
  output logic              shdn_o,
  output logic              healthy_o
);
  logic [NUM_CH-1:0] hact;
  logic [NUM_CH-1:0] set_vec;
  logic              crit;

  assign crit    = hits.rst | hits.poff | hits.shdn;
  assign set_vec = (acc && crit) ? (NUM_CH'(1) << ch) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_o <= '0;
      hact    <= '0;
      rst_o   <= 1'b0;
      poff_o  <= 1'b0;
      shdn_o  <= 1'b0;
    end else begin
      fault_o <= (fault_o & ~(clr_strobe ? clr_mask : '0)) | set_vec;
      if (acc) hact[ch] <= hits.hlth;
      rst_o  <= acc & hits.rst;
      poff_o <= acc & hits.poff;
      shdn_o <= acc & hits.shdn;
    end
  end

  assign healthy_o = ~|hact;

  // R7: without a clear no fault bit drops
  a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_strobe |=> ((fault_o & $past(fault_o)) == $past(fault_o)));
  // R6: a new fault bit only appears after a taken sample
  a_r6_fault_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault_o & ~$past(fault_o)) != '0) |-> $past(acc));
  // R8: trigger pulses only follow a taken sample
  a_r8_pulse_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_o || poff_o || shdn_o) |-> $past(acc));
  // R9: healthy only falls after a taken sample with a healthy-class hit
  a_r9_healthy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(healthy_o) |-> ($past(acc) && $past(hits.hlth)));
endmodule

// File: rtl/rail_limit_guard.sv
module rail_limit_guard
  import rlg_pkg::*;
#(
  parameter int                NUM_CH    = 11,
  parameter int                TEMP_CH   = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h80,
  localparam int               CH_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [CH_W-1:0]   smp_chan,
  input  logic [CODE_W-1:0] smp_code,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              clr_strobe,
  input  logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] fault_word,
  output logic              reset_req,
  output logic              healthy,
  output logic              poweroff_req,
  output logic              shutdown_req
);
  logic              chan_ok, acc;
  logic [CH_W-1:0]   idx;
  logic [CODE_W-1:0] lk_thr [LIM_PER_CH];
  logic [CLS_W-1:0]  lk_cls [LIM_PER_CH];
  class_hits_t       hits;

  assign smp_ready = rst_n;
  assign chan_ok   = int'(smp_chan) < NUM_CH;
  assign acc       = smp_valid && smp_ready && chan_ok;
  assign idx       = chan_ok ? smp_chan : '0;

  rlg_limit_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .lk_ch(idx), .lk_thr(lk_thr), .lk_cls(lk_cls));

  rlg_excursion_eval u_eval (
    .code(smp_code), .is_signed(idx == CH_W'(TEMP_CH)),
    .thr(lk_thr), .cls(lk_cls), .hits(hits));

  rlg_fault_tracker #(.NUM_CH(NUM_CH)) u_track (
    .clk(clk), .rst_n(rst_n), .acc(acc), .ch(idx), .hits(hits),
    .clr_strobe(clr_strobe), .clr_mask(clr_mask), .fault_o(fault_word),
    .rst_o(reset_req), .poff_o(poweroff_req), .shdn_o(shutdown_req), .healthy_o(healthy));

  // R10: a dropped tag leaves the fault word and pulses untouched
  a_r10_bad_tag_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !chan_ok && !clr_strobe) |=>
      ($stable(fault_word) && !reset_req && !poweroff_req && !shutdown_req));
endmodule

// File: tb/rail_limit_guard_test.sv
`timescale 1ns/1ps
module rail_limit_guard_test;
  logic        clk = 0, rst_n = 0;
  logic        smp_valid = 0, smp_ready;
  logic [3:0]  smp_chan = 0;
  logic [9:0]  smp_code = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic        clr_strobe = 0;
  logic [10:0] clr_mask = 0, fault_word;
  logic        reset_req, healthy, poweroff_req, shutdown_req;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] lim_m [11][4];
  logic [10:0] fault_m = 0;
  logic [10:0] hact_m = 0;

  always #4 clk = ~clk;

  rail_limit_guard uut (.*);

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exc(int ch, int k, logic [9:0] code);
    logic [9:0] t = lim_m[ch][k][9:0];
    bit lt, gt;
    if (ch == 8) begin lt = $signed(code) < $signed(t); gt = $signed(code) > $signed(t); end
    else         begin lt = code < t; gt = code > t; end
    return (k < 2) ? lt : gt;
  endfunction

  task automatic wr_word(int ch, int k, logic [15:0] w);
    reg_wr = 1; reg_addr = 8'(8'h80 + ch*8 + k*2); reg_wdata = w[15:8];
    @(negedge clk);
    reg_addr = reg_addr + 1; reg_wdata = w[7:0];
    @(negedge clk);
    reg_wr = 0;
    lim_m[ch][k] = w;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    reg_addr = a; #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic step(bit v, int ch, logic [9:0] code, bit c, logic [10:0] m, string tag);
    bit er = 0, eh = 0, ep = 0, es = 0;
    smp_valid = v; smp_chan = 4'(ch); smp_code = code; clr_strobe = c; clr_mask = m;
    @(negedge clk);
    smp_valid = 0; clr_strobe = 0;
    if (v && ch < 11) begin
      for (int k = 0; k < 4; k++) if (exc(ch, k, code)) begin
        er |= lim_m[ch][k][15]; eh |= lim_m[ch][k][14];
        ep |= lim_m[ch][k][13]; es |= lim_m[ch][k][12];
      end
      hact_m[ch] = eh;
    end
    fault_m = (fault_m & ~(c ? m : 11'd0)) | ((v && ch < 11 && (er|ep|es)) ? (11'd1 << ch) : 11'd0);
    chk(fault_word == fault_m, {tag, " fault_word"}, fault_word, fault_m);
    chk({reset_req, poweroff_req, shutdown_req} == {er, ep, es}, {tag, " pulses"},
        {reset_req, poweroff_req, shutdown_req}, {er, ep, es});
    chk(healthy == (hact_m == 0), {tag, " healthy"}, healthy, hact_m == 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 11; c++) for (int k = 0; k < 4; k++) lim_m[c][k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(fault_word == 0, "R1 fault", fault_word, 0);
    chk({reset_req, poweroff_req, shutdown_req} == 0, "R1 pulses", reset_req, 0);
    chk(healthy == 1, "R1 healthy", healthy, 1);
    chk(smp_ready == 1, "R1 ready", smp_ready, 1);
    rd(8'h80, 8'h00, "R1 limit byte");
    rd(8'hD7, 8'h00, "R1 last byte");

    // R2 map and R3 spare bits
    wr_word(3, 2, 16'hAD23);
    rd(8'h9C, 8'hAD, "R2 high byte");
    rd(8'h9D, 8'h23, "R2 low byte");
    reg_wr = 1; reg_addr = 8'hD8; reg_wdata = 8'h5A; @(negedge clk); reg_wr = 0;
    rd(8'hD8, 8'h00, "R2 outside high");
    rd(8'h7F, 8'h00, "R2 outside low");
    rd(8'h80, 8'h00, "R2 no alias");

    // R4 strict compares on channel 0
    wr_word(0, 0, 16'h8000 | 16'd100);
    wr_word(0, 2, 16'h2C00 | 16'd900);      // spare bits set: R3 no effect
    rd(8'h84, 8'h2F, "R3 spare readback");
    step(1, 0, 10'd100, 0, 0, "R4 under equal");
    chk(reset_req == 0, "R4 equal no trip", reset_req, 0);
    step(1, 0, 10'd99, 0, 0, "R4 under below");
    chk(reset_req == 1 && fault_word[0], "R4 below trips", reset_req, 1);
    step(0, 0, 0, 0, 0, "R8 pulse drops");
    chk(reset_req == 0, "R8 one cycle", reset_req, 0);
    step(1, 0, 10'd900, 1, 11'h001, "R7 clear");
    chk(fault_word[0] == 0, "R7 cleared", fault_word[0], 0);
    step(1, 0, 10'd901, 0, 0, "R4 over above");
    chk(poweroff_req == 1, "R8 poweroff", poweroff_req, 1);

    // R5 signed temperature
    wr_word(8, 2, 16'h1000 | 16'h010);
    wr_word(8, 0, 16'h8000 | 16'h3F0);
    step(1, 8, 10'h3F0, 0, 0, "R5 neg below over");
    chk(shutdown_req == 0, "R5 negative not over", shutdown_req, 0);
    step(1, 8, 10'd17, 0, 0, "R5 over");
    chk(shutdown_req == 1, "R5 shutdown", shutdown_req, 1);
    step(1, 8, 10'd5, 0, 0, "R5 positive not under");
    chk(reset_req == 0, "R5 positive ok", reset_req, 0);
    step(1, 8, 10'h3EF, 0, 0, "R5 neg under");
    chk(reset_req == 1, "R5 reset", reset_req, 1);

    // R6/R9 healthy-only
    wr_word(1, 3, 16'h4000 | 16'd500);
    step(1, 1, 10'd501, 0, 0, "R9 healthy low");
    chk(healthy == 0 && fault_word[1] == 0, "R6 healthy-only no fault", fault_word, 0);
    step(1, 1, 10'd400, 0, 0, "R9 healthy back");
    chk(healthy == 1, "R9 restored", healthy, 1);

    // R7 same-cycle set wins
    step(1, 0, 10'd5, 1, 11'h001, "R7 set beats clear");
    chk(fault_word[0] == 1, "R7 set wins", fault_word[0], 1);
    step(1, 2, 10'd5, 1, 11'h100, "R7 mask other bit");

    // R10 bad tag
    step(1, 11, 10'd0, 0, 0, "R10 tag 11");
    step(1, 15, 10'd1023, 0, 0, "R10 tag 15");

    // random phase
    void'($urandom(32'h5EED_0A1D));
    for (int c = 0; c < 11; c++) for (int k = 0; k < 4; k++) begin
      logic [15:0] w = 16'($urandom());
      w[11:10] = 2'($urandom());
      wr_word(c, k, w);
    end
    for (int i = 0; i < 400; i++) begin
      int ch = $urandom() % 13;
      int k  = $urandom() % 4;
      logic [9:0] code = 10'($urandom());
      if (ch < 11 && ($urandom() % 2)) code = lim_m[ch][k][9:0] + 10'($urandom() % 3) - 10'd1;
      step(1, ch, code, ($urandom() % 8) == 0, 11'($urandom()), "R4-random R6 R7 R8 R9");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule